// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block controls the maintenance side of a small direct-mapped data cache. It holds the tag, valid and dirty bits for every line and runs four maintenance operations on them. Three of them work on a byte address window and one works on the whole cache. The window operations are clean (write dirty data back), invalidate (drop lines) and clean-and-invalidate. The whole-cache operation is a full invalidate. Software programs the operations through a small register front end. A range operation takes a first-byte address and a last-byte address, and both ends are included. Software launches an operation with a control write, then polls the status or waits for the interrupt.

The sequencer steps through the line indices in ascending order, one line per cycle. A line is affected when its line address lies between the line-aligned start and end addresses. A dirty line that must be cleaned goes out on a request/acknowledge write-back port, and the walk stalls until the acknowledge arrives. The datapath uses a line-update port to install lines and a line-status port to observe them. Both ports stand in for the normal lookup and refill logic, which lives elsewhere.

Top module: `cmaint_top`

## Requirements
- R1: After reset the status register reads 0, no flag is set, irq is low and every line reads invalid and clean.
- R2: Writing control bit 1 while idle starts a full invalidate. Status bit 0 is set during the walk. Every line becomes invalid and clean with no write-back. The busy-end flag (status bit 2) is set at the end.
- R3: The operation code sits in control bits 3:2 and is encoded as 01 clean, 10 invalidate and 11 clean-and-invalidate. A range launch is a control write with bit 4 set. With code 00 the launch is ignored: status stays idle and no flag is set.
- R4: A line takes part in a range operation only when its line address ({tag, index}) lies between start>>log2(line bytes) and end>>log2(line bytes), both ends included.
- R5: Clean writes back every valid, dirty, in-range line at its line base address, in ascending index order. It then clears the dirty bit and leaves the line valid.
- R6: Invalidate clears valid and dirty on every in-range line and never requests a write-back.
- R7: Clean-and-invalidate writes back in-range dirty lines and leaves every in-range line invalid and clean.
- R8: wb_req stays high with a stable wb_addr until wb_ack. With no write-back needed, an operation stays busy for exactly LINES cycles.
- R9: A range operation sets status bit 1 while it runs. The command-end flag (status bit 3) is set when it ends.
- R10: A full-invalidate or range launch made while either busy bit is set is ignored and sets the error flag (status bit 4). The same applies to a range launch in the same write as a full-invalidate launch.
- R11: irq is high exactly when a flag is set and its enable bit is set. The enable register has busy-end in bit 0, command-end in bit 1 and error in bit 2.
- R12: A write to the clear register clears each flag whose bit is 1 in the same layout (0 busy-end, 1 command-end, 2 error) and leaves the other flags alone.
- R13: Clearing the enable bit (control bit 0) while an operation runs does not stop it. Busy stays set until the operation finishes with its normal result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control, 1 start, 2 end, 3 status, 4 enable, 5 clear |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| fill_en | input | 1 | Line-update strobe |
| fill_idx | input | log2(LINES) | Line index to update |
| fill_valid | input | 1 | Valid bit to install |
| fill_dirty | input | 1 | Dirty bit to install |
| fill_tag | input | TAG_W | Tag to install |
| probe_idx | input | log2(LINES) | Line index to observe |
| probe_valid | output | 1 | Valid bit of the observed line |
| probe_dirty | output | 1 | Dirty bit of the observed line |
| probe_tag | output | TAG_W | Tag of the observed line |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Byte address of the line being written back |
| wb_ack | input | 1 | Write-back acknowledge |

## Verification
A wrong range comparison or command decode shows up at once on the write-back port: a missing, extra or misordered wb_addr appears during the walk. It also shows up on the line-status port as soon as the busy bit drops. A walker that loses its index or state shows up in the status bits, either as a busy period of the wrong length (LINES cycles when no write-back is needed) or as a hang. Flag and enable faults show up on irq and on the status read in the cycle right after completion, or right after a clear or an illegal launch.

// File: rtl/cmaint_pkg.sv
// Shared types and register layout for the cache maintenance sequencer.
package cmaint_pkg;

    // Operation code; bit 0 marks the codes that write back dirty lines.
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_CLEAN = 2'b01,
        OP_INVAL = 2'b10,
        OP_CLINV = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'b00,
        W_SCAN = 2'b01,
        W_WB   = 2'b10
    } walk_e;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_START  = 3'd1;
    localparam logic [2:0] REG_END    = 3'd2;
    localparam logic [2:0] REG_STATUS = 3'd3;
    localparam logic [2:0] REG_IE     = 3'd4;
    localparam logic [2:0] REG_CLR    = 3'd5;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_FULL = 1;
    localparam int CTRL_OP   = 2;
    localparam int CTRL_GO   = 4;

    localparam int N_FLAGS = 3;   // bit 0 busy-end, bit 1 command-end, bit 2 error

endpackage

// File: rtl/cmaint_array.sv
// Tag, valid and dirty store, one register set per line.
// Assumes that line updates and maintenance clears never target the same
// line in the same cycle; if they do, the clear wins.
module cmaint_array #(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             fill_valid,
    input  logic             fill_dirty,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic             clr_valid,
    input  logic             clr_dirty,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] pr_idx,
    output logic             pr_valid,
    output logic             pr_dirty,
    output logic [TAG_W-1:0] pr_tag
);
    logic             valid_w [LINES];
    logic             dirty_w [LINES];
    logic [TAG_W-1:0] tag_w   [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic             d_q;
        logic [TAG_W-1:0] t_q;

        // Per-line state: install from the update port, then apply maintenance clears.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
            end else begin
                if (fill_en && fill_idx == IDX_W'(g)) begin
                    v_q <= fill_valid;
                    d_q <= fill_dirty;
                    t_q <= fill_tag;
                end
                if (clr_en && clr_idx == IDX_W'(g)) begin
                    if (clr_valid) v_q <= 1'b0;
                    if (clr_dirty) d_q <= 1'b0;
                end
            end
        end

        assign valid_w[g] = v_q;
        assign dirty_w[g] = d_q;
        assign tag_w[g]   = t_q;
    end

    assign rd_valid = valid_w[rd_idx];
    assign rd_dirty = dirty_w[rd_idx];
    assign rd_tag   = tag_w[rd_idx];
    assign pr_valid = valid_w[pr_idx];
    assign pr_dirty = dirty_w[pr_idx];
    assign pr_tag   = tag_w[pr_idx];

endmodule

// File: rtl/cmaint_walker.sv
// Line walker: steps through every index once per operation, decides the
// action for each line and stalls on the write-back handshake.
// Assumes launches arrive only while idle (the register block filters them).
module cmaint_walker
    import cmaint_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_full,
    input  logic              launch_range,
    input  op_e               launch_op,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [IDX_W-1:0]  idx,
    input  logic              rd_valid,
    input  logic              rd_dirty,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              clr_en,
    output logic              clr_valid,
    output logic              clr_dirty,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack,
    output logic              busy_full,
    output logic              busy_cmd,
    output logic              done_full,
    output logic              done_cmd
);
    localparam int LA_W = ADDR_W - OFF_W;

    walk_e            state_q;
    logic [IDX_W-1:0] idx_q;
    logic             full_q;
    op_e              op_q;
    logic [LA_W-1:0]  lo_q;
    logic [LA_W-1:0]  hi_q;

    logic [LA_W-1:0]  line_addr;
    logic             hit;
    logic             need_wb;
    logic             last;
    logic             done;
    logic             unused_offsets;

    assign unused_offsets = ^{start_addr[OFF_W-1:0], end_addr[OFF_W-1:0]};

    assign line_addr = {rd_tag, idx_q};
    assign hit       = rd_valid && (full_q || (line_addr >= lo_q && line_addr <= hi_q));
    assign need_wb   = (state_q == W_SCAN) && hit && rd_dirty && !full_q && op_q[0];
    assign last      = (idx_q == IDX_W'(LINES - 1));

    // Per-cycle line action and write-back request.
    always_comb begin
        clr_en    = 1'b0;
        clr_valid = 1'b0;
        clr_dirty = 1'b0;
        wb_req    = 1'b0;
        done      = 1'b0;
        case (state_q)
            W_SCAN: begin
                if (!need_wb) begin
                    if (hit && (full_q || op_q != OP_CLEAN)) begin
                        clr_en    = 1'b1;
                        clr_valid = 1'b1;
                        clr_dirty = 1'b1;
                    end
                    done = last;
                end
            end
            W_WB: begin
                wb_req = 1'b1;
                if (wb_ack) begin
                    clr_en    = 1'b1;
                    clr_dirty = 1'b1;
                    clr_valid = (op_q == OP_CLINV);
                    done      = last;
                end
            end
            default: ;
        endcase
    end

    // Walk state, line index and captured operation parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            idx_q   <= '0;
            full_q  <= 1'b0;
            op_q    <= OP_NONE;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            case (state_q)
                W_IDLE: begin
                    if (launch_full) begin
                        state_q <= W_SCAN;
                        full_q  <= 1'b1;
                        idx_q   <= '0;
                    end else if (launch_range) begin
                        state_q <= W_SCAN;
                        full_q  <= 1'b0;
                        op_q    <= launch_op;
                        idx_q   <= '0;
                        lo_q    <= start_addr[ADDR_W-1:OFF_W];
                        hi_q    <= end_addr[ADDR_W-1:OFF_W];
                    end
                end
                W_SCAN: begin
                    if (need_wb)   state_q <= W_WB;
                    else if (last) state_q <= W_IDLE;
                    else           idx_q   <= idx_q + 1'b1;
                end
                W_WB: begin
                    if (wb_ack) begin
                        if (last) begin
                            state_q <= W_IDLE;
                        end else begin
                            state_q <= W_SCAN;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign idx       = idx_q;
    assign wb_addr   = {line_addr, {OFF_W{1'b0}}};
    assign busy_full = (state_q != W_IDLE) && full_q;
    assign busy_cmd  = (state_q != W_IDLE) && !full_q;
    assign done_full = done && full_q;
    assign done_cmd  = done && !full_q;

endmodule

// File: rtl/cmaint_regs.sv
// Register front end: control, window, status, enables, write-one-to-clear
// flags and the interrupt. Filters launches made while the walker is busy.
// Assumes ADDR_W is at least 5 so that every control and status bit fits.
module cmaint_regs
    import cmaint_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              busy_full,
    input  logic              busy_cmd,
    input  logic              done_full,
    input  logic              done_cmd,
    output logic              launch_full,
    output logic              launch_range,
    output op_e               launch_op,
    output logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] end_addr,
    output logic              irq
);
    logic               en_q;
    op_e                op_q;
    logic [ADDR_W-1:0]  start_q;
    logic [ADDR_W-1:0]  end_q;
    logic [N_FLAGS-1:0] ie_q;
    logic [N_FLAGS-1:0] flag_q;

    logic               wr_ctrl;
    logic               req_full;
    logic               req_go;
    logic               busy_any;
    logic               launch_err;
    logic [N_FLAGS-1:0] flag_set;
    logic [N_FLAGS-1:0] flag_clr;
    logic               unused_wdata;

    assign unused_wdata = ^reg_wdata[ADDR_W-1:CTRL_GO+1];

    assign wr_ctrl      = reg_wr && reg_addr == REG_CTRL;
    assign req_full     = wr_ctrl && reg_wdata[CTRL_FULL];
    assign req_go       = wr_ctrl && reg_wdata[CTRL_GO];
    assign busy_any     = busy_full || busy_cmd;
    assign launch_op    = op_e'(reg_wdata[CTRL_OP+1:CTRL_OP]);
    assign launch_full  = req_full && !busy_any;
    assign launch_range = req_go && !busy_any && !req_full && launch_op != OP_NONE;
    assign launch_err   = (req_full && busy_any) || (req_go && (busy_any || req_full));

    assign flag_set = {launch_err, done_cmd, done_full};
    assign flag_clr = (reg_wr && reg_addr == REG_CLR) ? reg_wdata[N_FLAGS-1:0] : '0;

    // Programmable registers and sticky flags; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            op_q    <= OP_NONE;
            start_q <= '0;
            end_q   <= '0;
            ie_q    <= '0;
            flag_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q <= reg_wdata[CTRL_EN];
                op_q <= launch_op;
            end
            if (reg_wr && reg_addr == REG_START) start_q <= reg_wdata;
            if (reg_wr && reg_addr == REG_END)   end_q   <= reg_wdata;
            if (reg_wr && reg_addr == REG_IE)    ie_q    <= reg_wdata[N_FLAGS-1:0];
            flag_q <= flag_set | (flag_q & ~flag_clr);
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTRL_EN]             = en_q;
                reg_rdata[CTRL_OP+1:CTRL_OP]   = op_q;
            end
            REG_START:  reg_rdata = start_q;
            REG_END:    reg_rdata = end_q;
            REG_STATUS: reg_rdata[N_FLAGS+1:0] = {flag_q, busy_cmd, busy_full};
            REG_IE:     reg_rdata[N_FLAGS-1:0] = ie_q;
            default: ;
        endcase
    end

    assign start_addr = start_q;
    assign end_addr   = end_q;
    assign irq        = |(flag_q & ie_q);

endmodule

// File: rtl/cmaint_top.sv
// Cache range maintenance sequencer: register front end, line walker and
// tag/valid/dirty store. Assumes LINES and LINE_BYTES are powers of two and
// that line updates do not arrive while an operation runs.
module cmaint_top
    import cmaint_pkg::*;
#(
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 16,
    parameter int ADDR_W     = 16
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  reg_wr,
    input  logic [2:0]                                            reg_addr,
    input  logic [ADDR_W-1:0]                                     reg_wdata,
    output logic [ADDR_W-1:0]                                     reg_rdata,
    output logic                                                  irq,
    input  logic                                                  fill_en,
    input  logic [$clog2(LINES)-1:0]                              fill_idx,
    input  logic                                                  fill_valid,
    input  logic                                                  fill_dirty,
    input  logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-1:0]    fill_tag,
    input  logic [$clog2(LINES)-1:0]                              probe_idx,
    output logic                                                  probe_valid,
    output logic                                                  probe_dirty,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(LINES)-1:0]    probe_tag,
    output logic                                                  wb_req,
    output logic [ADDR_W-1:0]                                     wb_addr,
    input  logic                                                  wb_ack
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic              launch_full;
    logic              launch_range;
    op_e               launch_op;
    logic [ADDR_W-1:0] start_addr;
    logic [ADDR_W-1:0] end_addr;
    logic              busy_full;
    logic              busy_cmd;
    logic              done_full;
    logic              done_cmd;
    logic [IDX_W-1:0]  walk_idx;
    logic              rd_valid;
    logic              rd_dirty;
    logic [TAG_W-1:0]  rd_tag;
    logic              clr_en;
    logic              clr_valid;
    logic              clr_dirty;

    cmaint_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .busy_full    (busy_full),
        .busy_cmd     (busy_cmd),
        .done_full    (done_full),
        .done_cmd     (done_cmd),
        .launch_full  (launch_full),
        .launch_range (launch_range),
        .launch_op    (launch_op),
        .start_addr   (start_addr),
        .end_addr     (end_addr),
        .irq          (irq)
    );

    cmaint_walker #(
        .LINES  (LINES),
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W)
    ) u_walker (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch_full  (launch_full),
        .launch_range (launch_range),
        .launch_op    (launch_op),
        .start_addr   (start_addr),
        .end_addr     (end_addr),
        .idx          (walk_idx),
        .rd_valid     (rd_valid),
        .rd_dirty     (rd_dirty),
        .rd_tag       (rd_tag),
        .clr_en       (clr_en),
        .clr_valid    (clr_valid),
        .clr_dirty    (clr_dirty),
        .wb_req       (wb_req),
        .wb_addr      (wb_addr),
        .wb_ack       (wb_ack),
        .busy_full    (busy_full),
        .busy_cmd     (busy_cmd),
        .done_full    (done_full),
        .done_cmd     (done_cmd)
    );

    cmaint_array #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_en),
        .fill_idx   (fill_idx),
        .fill_valid (fill_valid),
        .fill_dirty (fill_dirty),
        .fill_tag   (fill_tag),
        .clr_en     (clr_en),
        .clr_idx    (walk_idx),
        .clr_valid  (clr_valid),
        .clr_dirty  (clr_dirty),
        .rd_idx     (walk_idx),
        .rd_valid   (rd_valid),
        .rd_dirty   (rd_dirty),
        .rd_tag     (rd_tag),
        .pr_idx     (probe_idx),
        .pr_valid   (probe_valid),
        .pr_dirty   (probe_dirty),
        .pr_tag     (probe_tag)
    );

endmodule

// File: rtl/cmaint_checker.sv
// Temporal checks on the maintenance sequencer, attached by bind.
// Assumes the flag vector layout: bit 0 busy-end, bit 1 command-end, bit 2 error.
module cmaint_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [ADDR_W-1:0] reg_wdata,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              busy_full,
    input logic              busy_cmd,
    input logic [2:0]        flags,
    input logic              irq
);
    p_wb_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(wb_addr));

    p_wb_in_range_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> busy_cmd);

    p_full_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[1] && !busy_full && !busy_cmd) |=> busy_full);

    p_bend_at_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(busy_full) && !busy_full);

    p_cend_at_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(busy_cmd) && !busy_cmd);

    p_err_on_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && (reg_wdata[1] || reg_wdata[4]) && (busy_full || busy_cmd))
        |=> flags[2]);

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b000) |-> !irq);

endmodule

bind cmaint_top cmaint_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .wb_req    (wb_req),
    .wb_ack    (wb_ack),
    .wb_addr   (wb_addr),
    .busy_full (busy_full),
    .busy_cmd  (busy_cmd),
    .flags     (u_regs.flag_q),
    .irq       (irq)
);

// File: tb/cmaint_top_bench.sv
`timescale 1ns/1ps
module cmaint_top_bench;
    localparam int LINES = 8;
    localparam int AW    = 16;
    localparam int TW    = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          irq;
    logic          fill_en = 1'b0;
    logic [2:0]    fill_idx = '0;
    logic          fill_valid = 1'b0;
    logic          fill_dirty = 1'b0;
    logic [TW-1:0] fill_tag = '0;
    logic [2:0]    probe_idx = '0;
    logic          probe_valid;
    logic          probe_dirty;
    logic [TW-1:0] probe_tag;
    logic          wb_req;
    logic [AW-1:0] wb_addr;
    logic          wb_ack = 1'b0;

    int errors = 0;
    int checks = 0;
    int ack_wait = 0;
    bit finished = 1'b0;

    bit            m_valid [LINES];
    bit            m_dirty [LINES];
    logic [TW-1:0] m_tag   [LINES];
    logic [AW-1:0] exp_wb[$];
    logic [AW-1:0] got_wb[$];

    always #2 clk = ~clk;

    cmaint_top u_cmaint_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_valid(fill_valid),
        .fill_dirty(fill_dirty), .fill_tag(fill_tag), .probe_idx(probe_idx),
        .probe_valid(probe_valid), .probe_dirty(probe_dirty), .probe_tag(probe_tag),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack)
    );

    // Write-back responder: random latency, one-cycle acknowledge, logs addresses.
    always @(negedge clk) begin
        if (wb_ack) begin
            wb_ack <= 1'b0;
        end else if (wb_req) begin
            if (ack_wait == 0) begin
                wb_ack <= 1'b1;
                got_wb.push_back(wb_addr);
                ack_wait = $urandom_range(0, 3);
            end else begin
                ack_wait = ack_wait - 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [AW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fill_line(input int i, input bit v, input bit d, input logic [TW-1:0] t);
        @(negedge clk);
        fill_en = 1'b1; fill_idx = 3'(i); fill_valid = v; fill_dirty = d; fill_tag = t;
        @(negedge clk);
        fill_en = 1'b0;
        m_valid[i] = v; m_dirty[i] = d; m_tag[i] = t;
    endtask

    task automatic wait_idle(input string req);
        logic [AW-1:0] st;
        int n = 0;
        reg_read(3'd3, st);
        while (st[1:0] != 2'b00 && n < 1000) begin
            reg_read(3'd3, st);
            n++;
        end
        if (n >= 1000) chk(req, "operation never finished", 1, 0);
    endtask

    // Expected effect of a range operation on the line model (R4-R7).
    task automatic model_range(input logic [1:0] op, input logic [AW-1:0] s, input logic [AW-1:0] e);
        logic [11:0] lo = s[15:4];
        logic [11:0] hi = e[15:4];
        exp_wb.delete();
        for (int i = 0; i < LINES; i++) begin
            logic [11:0] la = {m_tag[i], 3'(i)};
            if (m_valid[i] && la >= lo && la <= hi) begin
                if (op[0] && m_dirty[i]) exp_wb.push_back({la, 4'h0});
                if (op[0]) m_dirty[i] = 1'b0;
                if (op[1]) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; end
            end
        end
    endtask

    task automatic check_lines(input string req);
        for (int i = 0; i < LINES; i++) begin
            probe_idx = 3'(i);
            #1;
            chk(req, $sformatf("line %0d valid", i), probe_valid, m_valid[i]);
            chk(req, $sformatf("line %0d dirty", i), probe_dirty, m_dirty[i]);
            if (m_valid[i]) chk(req, $sformatf("line %0d tag", i), probe_tag, m_tag[i]);
        end
    endtask

    task automatic check_wb(input string req);
        chk(req, "write-back count", got_wb.size(), exp_wb.size());
        if (got_wb.size() == exp_wb.size())
            for (int k = 0; k < exp_wb.size(); k++)
                chk(req, $sformatf("write-back %0d address", k), got_wb[k], exp_wb[k]);
    endtask

    task automatic run_range(input string req, input logic [1:0] op,
                             input logic [AW-1:0] s, input logic [AW-1:0] e);
        logic [AW-1:0] st;
        got_wb.delete();
        model_range(op, s, e);
        reg_write(3'd1, s);
        reg_write(3'd2, e);
        reg_write(3'd0, AW'({op, 2'b00}) | 16'h0011);
        wait_idle(req);
        check_wb(req);
        check_lines(req);
        reg_read(3'd3, st);
        chk("R9", "command-end flag after range op", st[3], 1);
        reg_write(3'd5, 16'h0007);
    endtask

    task automatic fill_all(input logic [TW-1:0] t, input bit dirty_even_only);
        for (int i = 0; i < LINES; i++) fill_line(i, 1'b1, dirty_even_only ? (i % 2 == 0) : 1'b1, t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk("WD", "watchdog expired", 1, 0);
        summary();
    end

    initial begin
        logic [AW-1:0] st;
        int cnt;
        void'($urandom(32'd1711));
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(3'd3, st);
        chk("R1", "status after reset", st, 0);
        chk("R1", "irq after reset", irq, 0);
        reg_read(3'd0, st);
        chk("R1", "control after reset", st, 0);
        check_lines("R1");

        // R4/R5: clean over an unaligned start and an end on a line's first byte
        fill_all(9'd1, 1'b1);
        run_range("R5", 2'b01, 16'h009F, 16'h00C0);
        // R6: invalidate drops dirty lines without write-back
        run_range("R6", 2'b10, 16'h0000, 16'h009F);
        // R7: clean-and-invalidate over the whole space
        fill_all(9'd2, 1'b1);
        run_range("R7", 2'b11, 16'h0000, 16'hFFFF);
        // R4: window hitting exactly one line, both ends inside it
        fill_all(9'd3, 1'b0);
        run_range("R4", 2'b01, 16'h01A0, 16'h01AF);

        // R3: code 00 launch does nothing
        reg_write(3'd0, 16'h0011);
        reg_read(3'd3, st);
        chk("R3", "status after code-00 launch", st, 0);

        // R8: no write-back needed -> busy for exactly LINES cycles
        got_wb.delete(); model_range(2'b10, 16'h0000, 16'hFFFF);
        reg_write(3'd1, 16'h0000); reg_write(3'd2, 16'hFFFF);
        reg_write(3'd0, 16'h0019);
        reg_addr = 3'd3; cnt = 0;
        #1;
        while (reg_rdata[1] && cnt < 100) begin cnt++; @(negedge clk); #1; end
        chk("R8", "busy cycles of invalidate", cnt, LINES);
        check_wb("R6");
        reg_write(3'd5, 16'h0007);

        // R2: full invalidate with busy bit 0, busy-end flag, no write-back
        fill_all(9'd5, 1'b0);
        got_wb.delete(); exp_wb.delete();
        reg_write(3'd0, 16'h0003);
        reg_addr = 3'd3; cnt = 0;
        #1;
        chk("R2", "full-invalidate busy bit", reg_rdata[1:0], 2'b01);
        while (reg_rdata[0] && cnt < 100) begin cnt++; @(negedge clk); #1; end
        chk("R8", "busy cycles of full invalidate", cnt, LINES);
        chk("R2", "busy-end flag", reg_rdata[2], 1);
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 0; m_dirty[i] = 0; end
        check_lines("R2");
        check_wb("R2");
        reg_write(3'd5, 16'h0007);

        // R10: launch during a full invalidate is ignored and flagged
        fill_all(9'd6, 1'b1);
        got_wb.delete(); exp_wb.delete();
        reg_write(3'd1, 16'h0000); reg_write(3'd2, 16'hFFFF);
        reg_write(3'd0, 16'h0003);
        reg_write(3'd0, 16'h0015);
        wait_idle("R10");
        reg_read(3'd3, st);
        chk("R10", "error flag", st[4], 1);
        chk("R10", "no command-end from ignored launch", st[3], 0);
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 0; m_dirty[i] = 0; end
        check_wb("R10");
        check_lines("R10");

        // R11/R12: enables and write-one-to-clear (busy-end and error set now)
        reg_write(3'd4, 16'h0000);
        #1 chk("R11", "irq with enables off", irq, 0);
        reg_write(3'd4, 16'h0004);
        #1 chk("R11", "irq on error enable", irq, 1);
        reg_write(3'd5, 16'h0004);
        reg_read(3'd3, st);
        chk("R12", "error cleared, busy-end kept", st[4:2], 3'b001);
        chk("R11", "irq after error cleared", irq, 0);
        reg_write(3'd4, 16'h0001);
        #1 chk("R11", "irq on busy-end enable", irq, 1);
        reg_write(3'd5, 16'h0001);
        #1 chk("R12", "irq after busy-end cleared", irq, 0);
        reg_write(3'd4, 16'h0002);
        fill_all(9'd7, 1'b0);
        run_range("R11", 2'b10, 16'h0000, 16'h0000);
        reg_write(3'd4, 16'h0002);
        #1 chk("R12", "irq after clear of command-end", irq, 0);

        // R13: clearing enable mid-operation does not stop it
        fill_all(9'd4, 1'b0);
        got_wb.delete();
        model_range(2'b01, 16'h0000, 16'hFFFF);
        reg_write(3'd1, 16'h0000); reg_write(3'd2, 16'hFFFF);
        reg_write(3'd0, 16'h0015);
        reg_write(3'd0, 16'h0004);
        reg_read(3'd3, st);
        chk("R13", "still busy after enable cleared", st[1], 1);
        wait_idle("R13");
        reg_read(3'd3, st);
        chk("R13", "command-end after finish", st[3], 1);
        check_wb("R13");
        check_lines("R13");
        reg_write(3'd5, 16'h0007);

        // R4-R7: random windows and line contents
        for (int it = 0; it < 24; it++) begin
            logic [AW-1:0] s, e;
            logic [1:0] op;
            for (int i = 0; i < LINES; i++)
                fill_line(i, $urandom_range(0, 3) != 0, $urandom_range(0, 1), 9'($urandom_range(0, 3)));
            s  = 16'($urandom_range(0, 16'h01FF));
            e  = 16'($urandom_range(s, 16'h01FF));
            op = 2'($urandom_range(1, 3));
            run_range(op == 2'b01 ? "R5" : (op == 2'b10 ? "R6" : "R7"), op, s, e);
        end

        summary();
    end
endmodule